// File: doc/BRIEF.md
# Supply Supervisor Control Logic

This block is the digital half of a supply-voltage supervisor. Five analog comparators report whether the supply is below a power-on level, below each of two detect trips (low and high) and below each of two warning trips (low and high). The block turns those levels into a chip reset, two sticky flags that record what caused the last reset, a low-voltage event flag with its interrupt, and a warning flag. It also decides whether a requested stop mode may be entered.

Every comparator level passes through a two-flop synchronizer. The state that drives the chip reset is registered, so reset is released on a clock edge. Control bits come from a register file outside the block and are used as they arrive. A detector that is armed for stop cannot coexist with the deepest stop modes, so the block refuses those modes while that combination is set.

Top module: `vsup_ctrl`

## Requirements
- R1: A high level on `below_por_i` asserts `chip_rst_o` on the third rising clock edge after the change and sets both `src_por_o` and `src_lvd_o`. The same holds at `rst_n` release, when all comparators are taken as low-supply.
- R2: After a power-on event, `chip_rst_o` is released on the third edge after both `below_por_i` and `below_det_lo_i` are low. `below_det_hi_i` and `det_sel_hi_i` have no effect on this release.
- R3: With `det_en_i` and `rst_en_i` set, a high level on the selected detect comparator asserts `chip_rst_o`, sets `src_lvd_o` and clears `src_por_o`. The selected comparator is `below_det_hi_i` when `det_sel_hi_i`=1 and `below_det_lo_i` otherwise. Reset holds until that comparator goes low.
- R4: With `det_en_i` and `irq_en_i` set and `rst_en_i` clear, a detection sets `evt_flag_o` and `irq_o` without any reset. With `det_en_i` clear, a detection has no effect.
- R5: A one-cycle pulse on `evt_ack_i` clears `evt_flag_o` on the next edge. If the synchronized low condition is still present, the flag stays set.
- R6: While a permitted stop code is applied and `stop_arm_i` is clear, the detector ignores low conditions. With `stop_arm_i` set, the detector stays active in stop.
- R7: Stop codes on `stop_req_i` are 2'b00 run, 2'b01 stop1, 2'b10 stop2 and 2'b11 stop3. `stop_ok_o` is high for any non-zero code, except that stop1 and stop2 are refused while both `det_en_i` and `stop_arm_i` are set.
- R8: `warn_o` is high, outside reset, when the warning comparator chosen by `warn_sel_hi_i` is high and the selected detect comparator is low. It never drives `irq_o`.
- R9: `src_por_o` and `src_lvd_o` are cleared only by `src_clr_i` or by a reset event of the other type. `src_lvd_o` survives a detect reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous low-active register reset |
| below_por_i | input | 1 | Supply below power-on level (async) |
| below_det_lo_i | input | 1 | Supply below low detect trip (async) |
| below_det_hi_i | input | 1 | Supply below high detect trip (async) |
| below_warn_lo_i | input | 1 | Supply below low warning trip (async) |
| below_warn_hi_i | input | 1 | Supply below high warning trip (async) |
| det_en_i | input | 1 | Detector enable |
| det_sel_hi_i | input | 1 | Select high detect trip |
| rst_en_i | input | 1 | Detection causes reset |
| irq_en_i | input | 1 | Detection causes interrupt |
| stop_arm_i | input | 1 | Keep detector active in stop |
| warn_sel_hi_i | input | 1 | Select high warning trip |
| stop_req_i | input | 2 | Requested stop code |
| evt_ack_i | input | 1 | Write-one acknowledge of event flag |
| src_clr_i | input | 1 | Clear reset-source flags |
| chip_rst_o | output | 1 | Chip reset |
| src_por_o | output | 1 | Last reset caused by power-on |
| src_lvd_o | output | 1 | Last reset involved low voltage |
| evt_flag_o | output | 1 | Low-voltage event flag |
| irq_o | output | 1 | Low-voltage interrupt |
| warn_o | output | 1 | Low-voltage warning |
| stop_ok_o | output | 1 | Requested stop mode permitted |

## Verification
A hold state that is stuck or wrongly chosen shows up on `chip_rst_o` at the first release. In that case reset is let go while the deciding comparator is still high, or it is held after the comparator has cleared, three edges after the comparator changes. A wrong flag update shows up on `src_por_o` or `src_lvd_o` on the edge that enters reset and then persists. A lost sticky term in the event flag shows up on the edge after the acknowledge pulse.

// File: rtl/vsup_pkg.sv
package vsup_pkg;
    localparam int unsigned NCMP      = 5;
    localparam int unsigned IDX_POR   = 0;
    localparam int unsigned IDX_DETLO = 1;
    localparam int unsigned IDX_DETHI = 2;
    localparam int unsigned IDX_WRNLO = 3;
    localparam int unsigned IDX_WRNHI = 4;
    localparam int unsigned STOP_W    = 2;

    localparam logic [STOP_W-1:0] STOP_RUN = 2'b00;
    localparam logic [STOP_W-1:0] STOP_1   = 2'b01;
    localparam logic [STOP_W-1:0] STOP_2   = 2'b10;
    localparam logic [STOP_W-1:0] STOP_3   = 2'b11;

    typedef enum logic [1:0] {
        ST_RUN      = 2'd0,
        ST_HOLD_POR = 2'd1,
        ST_HOLD_DET = 2'd2
    } vsup_state_e;

    typedef struct packed {
        vsup_state_e state;
        logic        src_por;
        logic        src_lvd;
        logic        evt;
        logic        warn;
    } vsup_regs_t;
endpackage

// File: rtl/vsup_sync.sv
module vsup_sync #(
    parameter int unsigned WIDTH   = 5,
    parameter int unsigned STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] chain_q [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q[g] <= RST_VAL;
                end else if (g == 0) begin
                    chain_q[g] <= async_i;
                end else begin
                    chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/vsup_stop_gate.sv
module vsup_stop_gate
    import vsup_pkg::*;
(
    input  logic              det_en_i,
    input  logic              stop_arm_i,
    input  logic [STOP_W-1:0] stop_req_i,
    output logic              stop_ok_o
);
    logic deep_req;
    logic refuse;

    always_comb begin
        deep_req  = (stop_req_i == STOP_1) || (stop_req_i == STOP_2);
        refuse    = det_en_i && stop_arm_i && deep_req;
        stop_ok_o = (stop_req_i != STOP_RUN) && !refuse;
    end
endmodule

// File: rtl/vsup_ctrl.sv
module vsup_ctrl
    import vsup_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              below_por_i,
    input  logic              below_det_lo_i,
    input  logic              below_det_hi_i,
    input  logic              below_warn_lo_i,
    input  logic              below_warn_hi_i,
    input  logic              det_en_i,
    input  logic              det_sel_hi_i,
    input  logic              rst_en_i,
    input  logic              irq_en_i,
    input  logic              stop_arm_i,
    input  logic              warn_sel_hi_i,
    input  logic [STOP_W-1:0] stop_req_i,
    input  logic              evt_ack_i,
    input  logic              src_clr_i,
    output logic              chip_rst_o,
    output logic              src_por_o,
    output logic              src_lvd_o,
    output logic              evt_flag_o,
    output logic              irq_o,
    output logic              warn_o,
    output logic              stop_ok_o
);
    logic [NCMP-1:0] cmp_raw;
    logic [NCMP-1:0] cmp_s;
    logic            below_det;
    logic            below_warn;
    logic            det_live;
    logic            evt_cond;
    vsup_regs_t      r_d, r_q;

    assign cmp_raw = {below_warn_hi_i, below_warn_lo_i, below_det_hi_i,
                      below_det_lo_i, below_por_i};

    vsup_sync #(
        .WIDTH   (NCMP),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({NCMP{1'b1}})
    ) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (cmp_raw),
        .sync_o  (cmp_s)
    );

    vsup_stop_gate gate_i (
        .det_en_i   (det_en_i),
        .stop_arm_i (stop_arm_i),
        .stop_req_i (stop_req_i),
        .stop_ok_o  (stop_ok_o)
    );

    always_comb begin
        below_det  = det_sel_hi_i  ? cmp_s[IDX_DETHI] : cmp_s[IDX_DETLO];
        below_warn = warn_sel_hi_i ? cmp_s[IDX_WRNHI] : cmp_s[IDX_WRNLO];
        det_live   = det_en_i && (!stop_ok_o || stop_arm_i);
        evt_cond   = det_live && irq_en_i && !rst_en_i && below_det;

        r_d      = r_q;
        r_d.warn = 1'b0;
        if (src_clr_i) begin
            r_d.src_por = 1'b0;
            r_d.src_lvd = 1'b0;
        end

        case (r_q.state)
            ST_RUN: begin
                if (det_live && rst_en_i && below_det) begin
                    r_d.state   = ST_HOLD_DET;
                    r_d.src_lvd = 1'b1;
                    r_d.src_por = 1'b0;
                    r_d.evt     = 1'b0;
                end else begin
                    r_d.evt  = evt_cond || (r_q.evt && !evt_ack_i);
                    r_d.warn = below_warn && !below_det;
                end
            end
            ST_HOLD_POR: begin
                r_d.evt = 1'b0;
                if (!cmp_s[IDX_POR] && !cmp_s[IDX_DETLO]) begin
                    r_d.state = ST_RUN;
                end
            end
            ST_HOLD_DET: begin
                r_d.evt = 1'b0;
                if (!below_det) begin
                    r_d.state = ST_RUN;
                end
            end
            default: r_d.state = ST_HOLD_POR;
        endcase

        if (cmp_s[IDX_POR]) begin
            r_d.state   = ST_HOLD_POR;
            r_d.src_por = 1'b1;
            r_d.src_lvd = 1'b1;
            r_d.evt     = 1'b0;
            r_d.warn    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_HOLD_POR, src_por: 1'b1, src_lvd: 1'b1,
                     evt: 1'b0, warn: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign chip_rst_o = (r_q.state != ST_RUN);
    assign src_por_o  = r_q.src_por;
    assign src_lvd_o  = r_q.src_lvd;
    assign evt_flag_o = r_q.evt;
    assign irq_o      = r_q.evt && irq_en_i;
    assign warn_o     = r_q.warn;

    // R1: a synchronized power-on level yields reset with both source flags
    p_por_flags_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_s[IDX_POR] |=> (chip_rst_o && src_por_o && src_lvd_o));

    // R2: leaving a power-on hold needs the low detect level clear
    p_por_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_HOLD_POR && cmp_s[IDX_DETLO]) |=> chip_rst_o);

    // R3: a detect hold persists while the selected level is low
    p_det_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_HOLD_DET && below_det) |=> (chip_rst_o && src_lvd_o));

    // R4: a new event only follows an interrupt-mode configuration
    p_evt_cfg_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt_flag_o) |-> $past(irq_en_i && !rst_en_i && det_en_i));

    // R5: acknowledge never drops the flag while the condition persists
    p_ack_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_flag_o && evt_ack_i && evt_cond && !cmp_s[IDX_POR]) |=> evt_flag_o);

    // R7: deep stop refused while armed detector is enabled
    p_stop_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (det_en_i && stop_arm_i && stop_req_i != STOP_3) |-> !stop_ok_o);

    // R8: warning is never reported during reset
    p_warn_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        warn_o |-> !chip_rst_o);
endmodule

// File: tb/vsup_ctrl_tb.sv
module vsup_ctrl_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       por = 1'b0, dlo = 1'b0, dhi = 1'b0, wlo = 1'b0, whi = 1'b0;
    logic       det_en = 1'b0, det_sel_hi = 1'b0, rst_en = 1'b0, irq_en = 1'b0;
    logic       stop_arm = 1'b0, warn_sel_hi = 1'b0;
    logic [1:0] stop_req = 2'b00;
    logic       ack = 1'b0, src_clr = 1'b0;
    logic       chip_rst, src_por, src_lvd, evt_flag, irq, warn, stop_ok;
    int         n_run = 0;
    int         n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vsup_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .below_por_i(por), .below_det_lo_i(dlo), .below_det_hi_i(dhi),
        .below_warn_lo_i(wlo), .below_warn_hi_i(whi),
        .det_en_i(det_en), .det_sel_hi_i(det_sel_hi), .rst_en_i(rst_en),
        .irq_en_i(irq_en), .stop_arm_i(stop_arm), .warn_sel_hi_i(warn_sel_hi),
        .stop_req_i(stop_req), .evt_ack_i(ack), .src_clr_i(src_clr),
        .chip_rst_o(chip_rst), .src_por_o(src_por), .src_lvd_o(src_lvd),
        .evt_flag_o(evt_flag), .irq_o(irq), .warn_o(warn), .stop_ok_o(stop_ok)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what,
                         input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic pulse_clr();
        src_clr = 1'b1; tick(1); src_clr = 1'b0;
    endtask

    task automatic t_reset();
        #1;
        check("R1", "rst in reset", chip_rst, 1'b1);
        check("R1", "por flag in reset", src_por, 1'b1);
        check("R1", "lvd flag in reset", src_lvd, 1'b1);
        check("R4", "evt in reset", evt_flag, 1'b0);
        tick(2);
        rst_n = 1'b1;
        tick(2);
        check("R2", "held before sync clears", chip_rst, 1'b1);
        tick(1);
        check("R2", "released after sync", chip_rst, 1'b0);
        pulse_clr();
        check("R9", "por flag cleared", src_por, 1'b0);
        check("R9", "lvd flag cleared", src_lvd, 1'b0);
    endtask

    task automatic t_por();
        det_sel_hi = 1'b1;
        por = 1'b1; dlo = 1'b1; dhi = 1'b1;
        tick(2);
        check("R1", "no reset after two edges", chip_rst, 1'b0);
        tick(1);
        check("R1", "reset on third edge", chip_rst, 1'b1);
        check("R1", "por flag", src_por, 1'b1);
        check("R1", "lvd flag", src_lvd, 1'b1);
        por = 1'b0;
        tick(5);
        check("R2", "held while low trip low", chip_rst, 1'b1);
        dlo = 1'b0;
        tick(2);
        check("R2", "held before low trip synced", chip_rst, 1'b1);
        tick(1);
        check("R2", "released despite high trip", chip_rst, 1'b0);
        dhi = 1'b0;
        tick(3);
    endtask

    task automatic t_det_reset();
        pulse_clr();
        por = 1'b1; tick(3); por = 1'b0; tick(4);
        check("R9", "por flag before detect", src_por, 1'b1);
        det_en = 1'b1; rst_en = 1'b1; det_sel_hi = 1'b1;
        dhi = 1'b1;
        tick(3);
        check("R3", "detect reset", chip_rst, 1'b1);
        check("R3", "lvd flag", src_lvd, 1'b1);
        check("R9", "por flag cleared by detect", src_por, 1'b0);
        tick(5);
        check("R3", "hold while high trip low", chip_rst, 1'b1);
        dhi = 1'b0;
        tick(2);
        check("R3", "hold until synced", chip_rst, 1'b1);
        tick(1);
        check("R3", "release", chip_rst, 1'b0);
        check("R9", "lvd flag survives", src_lvd, 1'b1);
        rst_en = 1'b0; det_sel_hi = 1'b0;
    endtask

    task automatic t_irq();
        irq_en = 1'b1; det_en = 1'b0;
        dlo = 1'b1;
        tick(5);
        check("R4", "disabled detector ignored", evt_flag, 1'b0);
        det_en = 1'b1;
        tick(1);
        check("R4", "event flag set", evt_flag, 1'b1);
        check("R4", "interrupt", irq, 1'b1);
        check("R4", "no reset", chip_rst, 1'b0);
        ack = 1'b1; tick(1); ack = 1'b0;
        check("R5", "flag kept while low", evt_flag, 1'b1);
        dlo = 1'b0;
        tick(3);
        check("R5", "flag kept without ack", evt_flag, 1'b1);
        ack = 1'b1; tick(1); ack = 1'b0;
        check("R5", "flag cleared", evt_flag, 1'b0);
        check("R5", "irq cleared", irq, 1'b0);
        irq_en = 1'b0;
    endtask

    task automatic t_stop_code();
        det_en = 1'b1; stop_arm = 1'b1;
        stop_req = 2'b01; #1;
        check("R7", "stop1 refused", stop_ok, 1'b0);
        stop_req = 2'b10; #1;
        check("R7", "stop2 refused", stop_ok, 1'b0);
        stop_req = 2'b11; #1;
        check("R7", "stop3 allowed", stop_ok, 1'b1);
        stop_arm = 1'b0; stop_req = 2'b01; #1;
        check("R7", "stop1 allowed unarmed", stop_ok, 1'b1);
        stop_req = 2'b00; #1;
        check("R7", "run is no stop", stop_ok, 1'b0);
        tick(1);
    endtask

    task automatic t_stop_gate();
        det_en = 1'b1; rst_en = 1'b1; stop_arm = 1'b0; stop_req = 2'b11;
        dlo = 1'b1;
        tick(5);
        check("R6", "detector off in stop", chip_rst, 1'b0);
        stop_arm = 1'b1;
        tick(1);
        check("R6", "armed detector acts in stop", chip_rst, 1'b1);
        dlo = 1'b0;
        tick(3);
        check("R6", "release", chip_rst, 1'b0);
        stop_req = 2'b00; stop_arm = 1'b0; rst_en = 1'b0; det_en = 1'b0;
        tick(1);
    endtask

    task automatic t_warn();
        warn_sel_hi = 1'b0; wlo = 1'b1;
        tick(3);
        check("R8", "low warning", warn, 1'b1);
        warn_sel_hi = 1'b1;
        tick(1);
        check("R8", "high warning not low", warn, 1'b0);
        whi = 1'b1;
        tick(3);
        check("R8", "high warning", warn, 1'b1);
        det_sel_hi = 1'b1; dhi = 1'b1;
        tick(3);
        check("R8", "no warning below detect", warn, 1'b0);
        check("R8", "no irq from warning", irq, 1'b0);
        wlo = 1'b0; whi = 1'b0; dhi = 1'b0; det_sel_hi = 1'b0;
        tick(3);
        pulse_clr();
        check("R9", "lvd flag cleared at end", src_lvd, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        tick(1);
        t_reset();
        t_por();
        t_det_reset();
        t_irq();
        t_stop_code();
        t_stop_gate();
        t_warn();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule